// File: doc/BRIEF.md
# RTC time update engine

This block holds a calendar clock (seconds, minutes, hours, day of week, day of month, month and two-digit year) and moves it forward by one second each time a prescaler tick counter wraps. A host reaches the clock through a small register port with a fixed one-cycle read latency. It reads and writes a user copy of the time. The host can freeze that copy by setting a freeze bit. While the copy is frozen the internal counters keep running. Values the host writes during the freeze are loaded into the counters when the freeze bit is cleared.

A status register carries an update-pending flag. The flag rises a set number of prescaler ticks before each one-second update and drops when the update happens. A control register selects the number encoding (BCD or binary) and the hour format (12-hour or 24-hour) used at the port. It also enables automatic daylight-saving jumps. The internal counters are always binary and 24-hour, so changing a format bit changes only how values are shown and how written values are read. A one-cycle pulse is issued on every update, for the alarm and interrupt logic that lies outside this block.

Top module: `rtc_update_engine`

## Requirements
- R1: After reset the time reads 12 AM, 00:00, day of week 1, date 1, month 1, year 0. The control register reads 0x00 (BCD, 12-hour, daylight saving off, not frozen) and the status register reads 0x00. Register addresses are: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 status, 8 control.
- R2: Each update advances the time by exactly one second. An update happens once every TICKS_PER_SEC prescaler ticks. The same clock edge that changes the counters sets `upd_done_o`, and the pulse lasts one cycle.
- R3: The carries run seconds→minutes→hours→date→month→year. The day of week runs 1..7 and wraps to 1. February has 29 days when year mod 4 is 0 and 28 days otherwise. April, June, September and November have 30 days. Year 99 wraps to 00.
- R4: Status bit 7 reads 1 from the tick that leaves UIP_LEAD ticks before the update until the update itself, and reads 0 at all other times. Status bits 6..0 read 0, and writes to the status register have no effect.
- R5: Status bit 7 reads 0 whenever the freeze bit (control bit 7) is 1.
- R6: While the freeze bit is 1, reads of the time do not change across updates. Writes to the time registers are accepted while frozen. When the freeze bit is cleared after such a write, the written time becomes the live time and a full second passes before the next update. When the freeze bit is cleared with no write, the reads catch up with the live time.
- R7: Writes to the time registers while the freeze bit is 0 are ignored.
- R8: Control bit 1 = 1 selects 24-hour hours (0..23). Control bit 1 = 0 selects 12-hour hours (1..12), with bit 7 of the hours value set for PM. 11:59:59 AM is followed by 12:00:00 PM, and 11:59:59 PM is followed by 12:00:00 AM.
- R9: Control bit 2 = 1 selects binary values at the port and 0 selects BCD. The setting applies to reads and to writes.
- R10: With control bit 0 = 1, an update from 01:59:59 on a Sunday (day of week 1) in month 4 with date 1..7 goes to 03:00:00. On any other April Sunday the clock goes to 02:00:00.
- R11: With control bit 0 = 1, an update from 01:59:59 on a Sunday in month 10 with date 25 or later goes to 01:00:00. This jump is taken only once while the month stays 10, and the next pass through 01:59:59 goes on to 02:00:00.
- R12: Control bits 6..3 read 0. Bits 7, 2, 1 and 0 read back as written and are cleared only by reset.
- R13: A read strobe returns its data on `host_rdata_o` one cycle later, with `host_rvalid_o` high for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| presc_tick_i | input | 1 | One-cycle strobe from the oscillator prescaler |
| host_wr_i | input | 1 | Register write strobe |
| host_rd_i | input | 1 | Register read strobe |
| host_addr_i | input | ADDR_W | Register address |
| host_wdata_i | input | 8 | Write data |
| host_rdata_o | output | 8 | Read data, valid one cycle after the strobe |
| host_rvalid_o | output | 1 | High in the cycle read data is valid |
| upd_done_o | output | 1 | One-cycle pulse on each one-second update |

## Verification
The bench targets the rollovers most likely to be wrong. It checks the noon and midnight steps in 12-hour form, where an off-by-one mapping would show 00 or 13, and February 28/29 in leap and non-leap years, where a wrong month length would skip or repeat a day. It also checks the 99→00 year wrap. It checks the spring jump and its absence on a later Sunday. It runs the October fall-back twice to catch a design that repeats the hour without end. For the freeze it checks that reads hold still, that a clean release catches up without a restart, and that a loaded time waits a full second before its first update. A design that got this wrong would show a stale or early seconds value.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [6:0] year;
    logic [6:0] month;
    logic [6:0] date;
    logic [6:0] dow;
    logic [6:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } rtc_time_t;

  localparam rtc_time_t RTC_TIME_RESET = '{
    year: 7'd0, month: 7'd1, date: 7'd1, dow: 7'd1,
    hour: 7'd0, min: 7'd0, sec: 7'd0
  };

  // register addresses seen by the host
  localparam int REG_SEC   = 0;
  localparam int REG_MIN   = 1;
  localparam int REG_HOUR  = 2;
  localparam int REG_DOW   = 3;
  localparam int REG_DATE  = 4;
  localparam int REG_MONTH = 5;
  localparam int REG_YEAR  = 6;
  localparam int REG_STAT  = 7;
  localparam int REG_CTRL  = 8;

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [3:0] tens;
    logic [3:0] ones;
    tens = 4'(v / 7'd10);
    ones = 4'(v % 7'd10);
    return {tens, ones};
  endfunction

  function automatic logic [6:0] from_bcd(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] enc_field(input logic [6:0] v, input logic bin);
    logic [7:0] r;
    if (bin) r = {1'b0, v};
    else     r = to_bcd(v);
    return r;
  endfunction

  function automatic logic [6:0] dec_field(input logic [7:0] d, input logic bin);
    logic [6:0] r;
    if (bin) r = d[6:0];
    else     r = from_bcd(d);
    return r;
  endfunction

  // internal hours are 0..23; the 12-hour form puts PM in bit 7
  function automatic logic [7:0] enc_hour(input logic [6:0] h, input logic bin,
                                          input logic h24);
    logic [6:0] h12;
    logic [7:0] e;
    logic [7:0] r;
    if (h24) begin
      r = enc_field(h, bin);
    end else begin
      if (h == 7'd0)       h12 = 7'd12;
      else if (h > 7'd12)  h12 = h - 7'd12;
      else                 h12 = h;
      e = enc_field(h12, bin);
      r = {(h >= 7'd12), e[6:0]};
    end
    return r;
  endfunction

  function automatic logic [6:0] dec_hour(input logic [7:0] d, input logic bin,
                                          input logic h24);
    logic [6:0] h12;
    logic [6:0] base;
    logic [6:0] r;
    if (h24) begin
      r = dec_field(d, bin);
    end else begin
      h12  = dec_field({1'b0, d[6:0]}, bin);
      base = (h12 == 7'd12) ? 7'd0 : h12;
      r    = base + (d[7] ? 7'd12 : 7'd0);
    end
    return r;
  endfunction

  function automatic logic [6:0] days_in_month(input logic [6:0] month,
                                               input logic [6:0] year);
    logic [6:0] r;
    case (month)
      7'd2:                      r = (year[1:0] == 2'd0) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   r = 7'd30;
      default:                   r = 7'd31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_second_timer.sv
module rtc_second_timer #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_LEAD      = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic restart_i,
  output logic upd_stb_o,
  output logic uip_o
);

  localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);
  localparam logic [CNT_W-1:0] ARM  = CNT_W'(TICKS_PER_SEC - UIP_LEAD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             uip_q;

  assign upd_stb_o = tick_i && !restart_i && (cnt_q == LAST);
  assign uip_o     = uip_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_q <= '0;
      uip_q <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        uip_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == ARM) uip_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rtc_calendar_step.sv
module rtc_calendar_step
  import rtc_pkg::*;
(
  input  rtc_time_t cur_i,
  input  logic      dst_en_i,
  input  logic      fall_done_i,
  output rtc_time_t nxt_o,
  output logic      fall_hit_o
);

  logic       at_0159;
  logic       sunday;
  logic       spring_hit;
  logic [6:0] dim;

  assign at_0159    = (cur_i.hour == 7'd1) && (cur_i.min == 7'd59) && (cur_i.sec == 7'd59);
  assign sunday     = (cur_i.dow == 7'd1);
  assign spring_hit = dst_en_i && at_0159 && sunday &&
                      (cur_i.month == 7'd4) && (cur_i.date <= 7'd7);
  assign fall_hit_o = dst_en_i && at_0159 && sunday && !fall_done_i &&
                      (cur_i.month == 7'd10) && (cur_i.date >= 7'd25);
  assign dim        = days_in_month(cur_i.month, cur_i.year);

  always_comb begin
    nxt_o = cur_i;
    if (spring_hit) begin
      nxt_o.hour = 7'd3;
      nxt_o.min  = 7'd0;
      nxt_o.sec  = 7'd0;
    end else if (fall_hit_o) begin
      nxt_o.hour = 7'd1;
      nxt_o.min  = 7'd0;
      nxt_o.sec  = 7'd0;
    end else if (cur_i.sec != 7'd59) begin
      nxt_o.sec = cur_i.sec + 7'd1;
    end else begin
      nxt_o.sec = 7'd0;
      if (cur_i.min != 7'd59) begin
        nxt_o.min = cur_i.min + 7'd1;
      end else begin
        nxt_o.min = 7'd0;
        if (cur_i.hour != 7'd23) begin
          nxt_o.hour = cur_i.hour + 7'd1;
        end else begin
          nxt_o.hour = 7'd0;
          nxt_o.dow  = (cur_i.dow >= 7'd7) ? 7'd1 : cur_i.dow + 7'd1;
          if (cur_i.date < dim) begin
            nxt_o.date = cur_i.date + 7'd1;
          end else begin
            nxt_o.date = 7'd1;
            if (cur_i.month < 7'd12) begin
              nxt_o.month = cur_i.month + 7'd1;
            end else begin
              nxt_o.month = 7'd1;
              nxt_o.year  = (cur_i.year >= 7'd99) ? 7'd0 : cur_i.year + 7'd1;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/rtc_host_regs.sv
module rtc_host_regs
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  rtc_time_t         live_nxt_i,
  input  logic              uip_i,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o,
  output rtc_time_t         user_o,
  output logic              set_o,
  output logic              dst_en_o,
  output logic              load_o
);

  localparam logic [ADDR_W-1:0] A_SEC   = ADDR_W'(REG_SEC);
  localparam logic [ADDR_W-1:0] A_MIN   = ADDR_W'(REG_MIN);
  localparam logic [ADDR_W-1:0] A_HOUR  = ADDR_W'(REG_HOUR);
  localparam logic [ADDR_W-1:0] A_DOW   = ADDR_W'(REG_DOW);
  localparam logic [ADDR_W-1:0] A_DATE  = ADDR_W'(REG_DATE);
  localparam logic [ADDR_W-1:0] A_MONTH = ADDR_W'(REG_MONTH);
  localparam logic [ADDR_W-1:0] A_YEAR  = ADDR_W'(REG_YEAR);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(REG_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(REG_CTRL);

  logic      set_q, bin_q, h24_q, dse_q, dirty_q;
  logic      rvalid_q;
  logic [7:0] rdata_q;
  logic [7:0] rd_mux;
  rtc_time_t user_q;
  logic      wr_ctrl, wr_time, release_freeze;

  assign wr_ctrl        = wr_i && (addr_i == A_CTRL);
  assign wr_time        = wr_i && set_q && (addr_i <= A_YEAR);
  assign release_freeze = wr_ctrl && set_q && !wdata_i[7];
  assign load_o         = release_freeze && dirty_q;

  assign user_o   = user_q;
  assign set_o    = set_q;
  assign dst_en_o = dse_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  always_comb begin
    case (addr_i)
      A_SEC:   rd_mux = enc_field(user_q.sec, bin_q);
      A_MIN:   rd_mux = enc_field(user_q.min, bin_q);
      A_HOUR:  rd_mux = enc_hour(user_q.hour, bin_q, h24_q);
      A_DOW:   rd_mux = enc_field(user_q.dow, bin_q);
      A_DATE:  rd_mux = enc_field(user_q.date, bin_q);
      A_MONTH: rd_mux = enc_field(user_q.month, bin_q);
      A_YEAR:  rd_mux = enc_field(user_q.year, bin_q);
      A_STAT:  rd_mux = {uip_i && !set_q, 7'b0};
      A_CTRL:  rd_mux = {set_q, 4'b0, bin_q, h24_q, dse_q};
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      set_q    <= 1'b0;
      bin_q    <= 1'b0;
      h24_q    <= 1'b0;
      dse_q    <= 1'b0;
      dirty_q  <= 1'b0;
      user_q   <= RTC_TIME_RESET;
      rvalid_q <= 1'b0;
      rdata_q  <= 8'h00;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) rdata_q <= rd_mux;

      if (wr_ctrl) begin
        set_q <= wdata_i[7];
        bin_q <= wdata_i[2];
        h24_q <= wdata_i[1];
        dse_q <= wdata_i[0];
      end

      if (release_freeze)  dirty_q <= 1'b0;
      else if (wr_time)    dirty_q <= 1'b1;

      if (!set_q) begin
        user_q <= live_nxt_i;
      end else if (wr_time) begin
        case (addr_i)
          A_SEC:   user_q.sec   <= dec_field(wdata_i, bin_q);
          A_MIN:   user_q.min   <= dec_field(wdata_i, bin_q);
          A_HOUR:  user_q.hour  <= dec_hour(wdata_i, bin_q, h24_q);
          A_DOW:   user_q.dow   <= dec_field(wdata_i, bin_q);
          A_DATE:  user_q.date  <= dec_field(wdata_i, bin_q);
          A_MONTH: user_q.month <= dec_field(wdata_i, bin_q);
          default: user_q.year  <= dec_field(wdata_i, bin_q);
        endcase
      end
    end
  end

endmodule

// File: rtl/rtc_update_engine.sv
module rtc_update_engine
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_LEAD      = 8,
  parameter int ADDR_W        = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              presc_tick_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [7:0]        host_wdata_i,
  output logic [7:0]        host_rdata_o,
  output logic              host_rvalid_o,
  output logic              upd_done_o
);

  rtc_time_t live_q;
  rtc_time_t live_nxt;
  rtc_time_t step_nxt;
  rtc_time_t user_time;
  logic      fall_hit;
  logic      fall_done_q;
  logic      upd_stb;
  logic      uip_q;
  logic      set_q;
  logic      dst_en;
  logic      load;
  logic      upd_done_q;

  rtc_second_timer #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .UIP_LEAD      (UIP_LEAD)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (presc_tick_i),
    .restart_i (load),
    .upd_stb_o (upd_stb),
    .uip_o     (uip_q)
  );

  rtc_calendar_step u_step (
    .cur_i       (live_q),
    .dst_en_i    (dst_en),
    .fall_done_i (fall_done_q),
    .nxt_o       (step_nxt),
    .fall_hit_o  (fall_hit)
  );

  rtc_host_regs #(
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (host_wr_i),
    .rd_i       (host_rd_i),
    .addr_i     (host_addr_i),
    .wdata_i    (host_wdata_i),
    .live_nxt_i (live_nxt),
    .uip_i      (uip_q),
    .rdata_o    (host_rdata_o),
    .rvalid_o   (host_rvalid_o),
    .user_o     (user_time),
    .set_o      (set_q),
    .dst_en_o   (dst_en),
    .load_o     (load)
  );

  always_comb begin
    if (load)         live_nxt = user_time;
    else if (upd_stb) live_nxt = step_nxt;
    else              live_nxt = live_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q      <= RTC_TIME_RESET;
      fall_done_q <= 1'b0;
      upd_done_q  <= 1'b0;
    end else begin
      live_q     <= live_nxt;
      upd_done_q <= upd_stb;
      if (upd_stb && fall_hit)         fall_done_q <= 1'b1;
      else if (live_q.month != 7'd10)  fall_done_q <= 1'b0;
    end
  end

  assign upd_done_o = upd_done_q;

endmodule

// File: rtl/rtc_update_engine_chk.sv
module rtc_update_engine_chk
  import rtc_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      presc_tick_i,
  input logic      host_wr_i,
  input logic      host_rd_i,
  input logic      host_rvalid_o,
  input logic      upd_done_o,
  input logic      upd_stb,
  input logic      uip_q,
  input logic      set_q,
  input rtc_time_t user_time
);

  // R2
  upd_done_single_chk: assert property (@(posedge clk) disable iff (rst)
    upd_done_o |=> !upd_done_o);

  // R2
  upd_done_tick_chk: assert property (@(posedge clk) disable iff (rst)
    upd_done_o |-> $past(presc_tick_i));

  // R4
  uip_before_update_chk: assert property (@(posedge clk) disable iff (rst)
    upd_stb |-> uip_q);

  // R4
  uip_drop_chk: assert property (@(posedge clk) disable iff (rst)
    upd_done_o |-> !uip_q);

  // R6
  frozen_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (set_q && !host_wr_i) |=> $stable(user_time));

  // R13
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    host_rd_i |=> host_rvalid_o);

  // R13
  rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !host_rd_i |=> !host_rvalid_o);

endmodule

bind rtc_update_engine rtc_update_engine_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .presc_tick_i  (presc_tick_i),
  .host_wr_i     (host_wr_i),
  .host_rd_i     (host_rd_i),
  .host_rvalid_o (host_rvalid_o),
  .upd_done_o    (upd_done_o),
  .upd_stb       (upd_stb),
  .uip_q         (uip_q),
  .set_q         (set_q),
  .user_time     (user_time)
);

// File: tb/rtc_update_engine_tb.sv
module rtc_update_engine_tb;

  localparam int TPS  = 8;
  localparam int LEAD = 2;
  localparam int AW   = 4;

  localparam int SEC = 0, MIN = 1, HOUR = 2, DOW = 3, DATE = 4,
                 MONTH = 5, YEAR = 6, STAT = 7, CTRL = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          presc_tick = 1'b0;
  logic          host_wr = 1'b0;
  logic          host_rd = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0]    host_wdata = 8'h00;
  logic [7:0]    host_rdata;
  logic          host_rvalid;
  logic          upd_done;

  int checks = 0;
  int errors = 0;
  int total_ticks = 0;
  int pulses = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  rtc_update_engine #(
    .TICKS_PER_SEC (TPS),
    .UIP_LEAD      (LEAD),
    .ADDR_W        (AW)
  ) u_dut (
    .clk           (clk),
    .rst           (rst),
    .presc_tick_i  (presc_tick),
    .host_wr_i     (host_wr),
    .host_rd_i     (host_rd),
    .host_addr_i   (host_addr),
    .host_wdata_i  (host_wdata),
    .host_rdata_o  (host_rdata),
    .host_rvalid_o (host_rvalid),
    .upd_done_o    (upd_done)
  );

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data in order
  always @(negedge clk) begin
    if (!rst && upd_done) pulses++;
    if (host_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R13 unrequested read data actual=%02h expected=none", host_rdata);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (host_rdata !== e) begin
          errors++;
          $display("FAIL %s actual=%02h expected=%02h", t, host_rdata, e);
        end
      end
    end
  end

  task automatic rd(input int a, input logic [7:0] e, input string tag);
    @(negedge clk);
    host_rd   = 1'b1;
    host_addr = AW'(a);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    host_wr    = 1'b1;
    host_addr  = AW'(a);
    host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      presc_tick = 1'b1;
      @(negedge clk);
      presc_tick = 1'b0;
      total_ticks++;
    end
  endtask

  task automatic load_time(input logic [7:0] ctl, input logic [7:0] hh,
                           input logic [7:0] mm, input logic [7:0] ss);
    wr(CTRL, ctl | 8'h80);
    wr(HOUR, hh);
    wr(MIN, mm);
    wr(SEC, ss);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(SEC, 8'h00, "R1 sec");
    rd(MIN, 8'h00, "R1 min");
    rd(HOUR, 8'h12, "R1 hour 12AM");
    rd(DOW, 8'h01, "R1 dow");
    rd(DATE, 8'h01, "R1 date");
    rd(MONTH, 8'h01, "R1 month");
    rd(YEAR, 8'h00, "R1 year");
    rd(CTRL, 8'h00, "R1 ctrl");
    rd(STAT, 8'h00, "R1 stat");

    // R4 update-pending window, R5 masked by freeze
    tick_n(5);
    rd(STAT, 8'h00, "R4 stat before window");
    tick_n(1);
    rd(STAT, 8'h80, "R4 stat in window");
    wr(CTRL, 8'h80);
    rd(STAT, 8'h00, "R5 stat while frozen");
    wr(CTRL, 8'h00);
    rd(STAT, 8'h80, "R4 stat after clean release");
    tick_n(1);
    rd(STAT, 8'h80, "R4 stat last tick");
    tick_n(1);
    rd(STAT, 8'h00, "R4 stat after update");
    rd(SEC, 8'h01, "R2 one second");
    check_int("R2 pulse count", pulses, 1);
    wr(STAT, 8'hFF);
    rd(STAT, 8'h00, "R4 status write ignored");

    // R7 writes ignored when not frozen
    wr(SEC, 8'h30);
    rd(SEC, 8'h01, "R7 sec write ignored");
    wr(HOUR, 8'h05);
    rd(HOUR, 8'h12, "R7 hour write ignored");

    // R12 reserved control bits, R9 binary read
    wr(CTRL, 8'h7E);
    rd(CTRL, 8'h06, "R12 ctrl readback");
    rd(HOUR, 8'h00, "R9 binary 24h hour");
    wr(CTRL, 8'h00);
    rd(CTRL, 8'h00, "R12 ctrl cleared");

    // R8 noon and midnight in 12h BCD
    load_time(8'h00, 8'h11, 8'h59, 8'h59);
    wr(CTRL, 8'h00);
    tick_n(TPS);
    rd(HOUR, 8'h92, "R8 12PM after 11:59:59AM");
    rd(MIN, 8'h00, "R8 min rollover");
    rd(SEC, 8'h00, "R8 sec rollover");
    load_time(8'h00, 8'h91, 8'h59, 8'h59);
    wr(CTRL, 8'h00);
    tick_n(TPS);
    rd(HOUR, 8'h12, "R8 12AM after 11:59:59PM");
    rd(DATE, 8'h02, "R3 date advance");
    rd(DOW, 8'h02, "R3 dow advance");

    // R9 binary 24h writes, R3 leap February
    load_time(8'h06, 8'h17, 8'h3B, 8'h3B);
    wr(DATE, 8'h1C);
    wr(MONTH, 8'h02);
    wr(YEAR, 8'h04);
    wr(DOW, 8'h07);
    wr(CTRL, 8'h06);
    tick_n(TPS);
    rd(DATE, 8'h1D, "R3 leap Feb 29 binary");
    rd(MONTH, 8'h02, "R3 leap month held");
    rd(DOW, 8'h01, "R3 dow wrap");
    rd(HOUR, 8'h00, "R9 binary midnight");
    wr(CTRL, 8'h00);
    rd(DATE, 8'h29, "R9 BCD view of 29");
    rd(HOUR, 8'h12, "R8 12h view of midnight");

    // R3 non-leap February
    load_time(8'h02, 8'h23, 8'h59, 8'h59);
    wr(YEAR, 8'h03);
    wr(MONTH, 8'h02);
    wr(DATE, 8'h28);
    wr(CTRL, 8'h02);
    tick_n(TPS);
    rd(MONTH, 8'h03, "R3 non-leap month");
    rd(DATE, 8'h01, "R3 non-leap date");

    // R3 year wrap
    load_time(8'h02, 8'h23, 8'h59, 8'h59);
    wr(YEAR, 8'h99);
    wr(MONTH, 8'h12);
    wr(DATE, 8'h31);
    wr(CTRL, 8'h02);
    tick_n(TPS);
    rd(YEAR, 8'h00, "R3 year wrap");
    rd(MONTH, 8'h01, "R3 month wrap");
    rd(DATE, 8'h01, "R3 date wrap");
    rd(HOUR, 8'h00, "R3 hour wrap");

    // R6 freeze, load and catch-up
    load_time(8'h02, 8'h10, 8'h00, 8'h00);
    wr(CTRL, 8'h02);
    tick_n(TPS - 1);
    rd(SEC, 8'h00, "R6 full second after load");
    tick_n(1);
    rd(SEC, 8'h01, "R6 first update after load");
    wr(CTRL, 8'h82);
    tick_n(TPS);
    rd(SEC, 8'h01, "R6 frozen copy");
    wr(CTRL, 8'h02);
    rd(SEC, 8'h02, "R6 catch-up on clean release");

    // R10 spring jump
    load_time(8'h03, 8'h01, 8'h59, 8'h59);
    wr(YEAR, 8'h00);
    wr(MONTH, 8'h04);
    wr(DATE, 8'h02);
    wr(DOW, 8'h01);
    wr(CTRL, 8'h03);
    tick_n(TPS);
    rd(HOUR, 8'h03, "R10 spring jump hour");
    rd(MIN, 8'h00, "R10 spring jump min");
    load_time(8'h03, 8'h01, 8'h59, 8'h59);
    wr(DATE, 8'h09);
    wr(DOW, 8'h01);
    wr(CTRL, 8'h03);
    tick_n(TPS);
    rd(HOUR, 8'h02, "R10 no jump second Sunday");

    // R11 fall-back once
    load_time(8'h03, 8'h01, 8'h59, 8'h59);
    wr(MONTH, 8'h10);
    wr(DATE, 8'h26);
    wr(DOW, 8'h01);
    wr(CTRL, 8'h03);
    tick_n(TPS);
    rd(HOUR, 8'h01, "R11 fall back hour");
    rd(MIN, 8'h00, "R11 fall back min");
    load_time(8'h03, 8'h01, 8'h59, 8'h59);
    wr(CTRL, 8'h03);
    tick_n(TPS);
    rd(HOUR, 8'h02, "R11 second pass not repeated");

    repeat (4) @(negedge clk);
    check_int("R13 all reads answered", exp_q.size(), 0);
    check_int("R2 total pulses", pulses, total_ticks / TPS);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule